// File: doc/BRIEF.md
# Reference Clock Switchover Sequencer

This controller sits next to a PLL that can take its reference from either of two input clocks. It runs entirely on a free-running system clock and turns a software or board-level switch request into a safe, ordered changeover. It selects the other reference, pulses the PLL reset, waits for the PLL to report lock, and only then lets the downstream output clocks run again.

Each request flips the selection to the other reference. The controller first confirms that both references are alive. Each reference supplies a divided toggle signal, which the block resynchronizes and watches for activity within a window of system cycles. If either reference is silent, the request is refused and a sticky flag records the refusal. The wait for lock has no fixed length. A timeout bounds it: when the timeout expires, an error flag is raised and the outputs stay gated. The lock flag is expected to be synchronous to the system clock already.

Top module: `refclk_switch_seq`

## Requirements
- R1: During and after reset, `ref_sel_o`=0, `pll_rst_o`=0, `out_en_o`=0, `refused_o`=0 and `lock_err_o`=0. The block starts busy, waiting for lock, and raises `out_en_o` once lock is seen.
- R2: Only a 0→1 transition of `sw_req_i`, sampled on the system clock, starts a sequence. Holding the request high does not start another sequence. Its falling edge never returns the selection to the previous reference.
- R3: An accepted request inverts `ref_sel_o` (0 = first reference, 1 = second) exactly once. The change comes two clock edges after the edge that sampled the rising request. `ref_sel_o` changes at no other time.
- R4: If either reference is not alive one edge after the request is sampled, the sequence is abandoned. `ref_sel_o`, `out_en_o` and `pll_rst_o` stay as they were, and `refused_o` goes to 1.
- R5: A reference counts as alive when a change of its toggle input reached the end of a three-flop synchronizer within the last `ACT_WINDOW` edges. A change is seen three edges after it is presented. Out of reset, both references count as dead until a toggle is seen.
- R6: `pll_rst_o` is high for exactly `RST_CYCLES` cycles, starting at the edge where `ref_sel_o` changes. `RST_CYCLES` is the smallest whole number of system periods covering 10 ns (2 at the default 8 ns period).
- R7: `out_en_o` falls at the edge where `ref_sel_o` changes. After the reset pulse it rises one edge after the first edge at which `pll_locked_i` is sampled high.
- R8: If lock is not seen within `LOCK_TIMEOUT` cycles after the reset pulse, `lock_err_o` is set, the block goes idle, and `out_en_o` stays 0 even if lock returns later. `lock_err_o` clears when a later sequence enables the outputs.
- R9: A rising request that arrives while `busy_o` is 1 is ignored and changes no output.
- R10: `refused_o` stays set until the next accepted request, which clears it one edge after that request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req_i | input | 1 | Switch request, acted on at its rising edge |
| ref0_tgl_i | input | 1 | Toggle derived from reference 0 (asynchronous) |
| ref1_tgl_i | input | 1 | Toggle derived from reference 1 (asynchronous) |
| pll_locked_i | input | 1 | PLL lock indication, system-clock synchronous |
| ref_sel_o | output | 1 | Selected reference: 0 or 1 |
| pll_rst_o | output | 1 | PLL reset pulse |
| out_en_o | output | 1 | Enable for the PLL output clocks |
| busy_o | output | 1 | A sequence (or start-up lock wait) is in progress |
| refused_o | output | 1 | Sticky: last request refused for a dead reference |
| lock_err_o | output | 1 | Lock was not regained before the timeout |

## Verification
A request sampled at edge k is judged at edge k+1. The selection flip and the enable drop are due at edge k+2. The reset pulse covers the following `RST_CYCLES` cycles, and the enable returns one edge after lock is first sampled. A toggle change becomes visible to the alive check three edges after it is driven. The bench drives inputs on falling edges and advances a behavioural reference model on every rising edge. It compares all six outputs at the next falling edge, so every result is checked in exactly the cycle it is due. Directed checks after each scenario cover the refusal, timeout, held-request and busy-request cases.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SWITCH,
        ST_RSTPULSE,
        ST_WAITLOCK,
        ST_ENABLE
    } seq_state_e;

    typedef struct packed {
        logic sel;
        logic pll_rst;
        logic out_en;
        logic busy;
        logic refused;
        logic lock_err;
    } seq_out_t;

    // smallest number of clock periods covering a duration, never below one
    function automatic int cycles_for_ps(input int dur_ps, input int period_ps);
        int c;
        c = (dur_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/refsw_activity_mon.sv
module refsw_activity_mon #(
    parameter int WINDOW = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_i,
    output logic alive_o
);
    localparam int CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] CNT_DEAD = CW'(WINDOW);

    logic [2:0]    sync_q;
    logic [CW-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '0;
            quiet_q <= CNT_DEAD;
        end else begin
            sync_q <= {sync_q[1:0], tgl_i};
            if (sync_q[2] ^ sync_q[1])
                quiet_q <= '0;
            else if (quiet_q != CNT_DEAD)
                quiet_q <= quiet_q + 1'b1;
        end
    end

    assign alive_o = (quiet_q != CNT_DEAD);
endmodule

// File: rtl/refsw_req_edge.sv
module refsw_req_edge (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= req_i;
    end

    assign rise_o = req_i & ~prev_q;
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
    import refsw_pkg::*;
#(
    parameter int RST_CYCLES   = 2,
    parameter int LOCK_TIMEOUT = 40
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     refs_ok_i,
    input  logic     locked_i,
    output seq_out_t out_o
);
    localparam int CNT_MAX = (RST_CYCLES > LOCK_TIMEOUT) ? RST_CYCLES : LOCK_TIMEOUT;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYCLES - 1);
    localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_TIMEOUT - 1);

    seq_state_e    st_q;
    logic [CW-1:0] cnt_q;
    logic          sel_q, en_q, refused_q, err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_WAITLOCK;
            cnt_q     <= '0;
            sel_q     <= 1'b0;
            en_q      <= 1'b0;
            refused_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) st_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (refs_ok_i) begin
                        refused_q <= 1'b0;
                        st_q      <= ST_SWITCH;
                    end else begin
                        refused_q <= 1'b1;
                        st_q      <= ST_IDLE;
                    end
                end
                ST_SWITCH: begin
                    sel_q <= ~sel_q;
                    en_q  <= 1'b0;
                    cnt_q <= '0;
                    st_q  <= ST_RSTPULSE;
                end
                ST_RSTPULSE: begin
                    if (cnt_q == RST_LAST) begin
                        cnt_q <= '0;
                        st_q  <= ST_WAITLOCK;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WAITLOCK: begin
                    if (locked_i) begin
                        st_q <= ST_ENABLE;
                    end else if (cnt_q == LOCK_LAST) begin
                        err_q <= 1'b1;
                        cnt_q <= '0;
                        st_q  <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_ENABLE: begin
                    en_q  <= 1'b1;
                    err_q <= 1'b0;
                    st_q  <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        out_o.sel      = sel_q;
        out_o.pll_rst  = (st_q == ST_RSTPULSE);
        out_o.out_en   = en_q;
        out_o.busy     = (st_q != ST_IDLE);
        out_o.refused  = refused_q;
        out_o.lock_err = err_q;
    end
endmodule

// File: rtl/refclk_switch_seq.sv
module refclk_switch_seq
    import refsw_pkg::*;
#(
    parameter int SYS_PERIOD_PS = 8000,
    parameter int RST_MIN_PS    = 10000,
    parameter int ACT_WINDOW    = 16,
    parameter int LOCK_TIMEOUT  = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_req_i,
    input  logic ref0_tgl_i,
    input  logic ref1_tgl_i,
    input  logic pll_locked_i,
    output logic ref_sel_o,
    output logic pll_rst_o,
    output logic out_en_o,
    output logic busy_o,
    output logic refused_o,
    output logic lock_err_o
);
    localparam int RST_CYCLES = cycles_for_ps(RST_MIN_PS, SYS_PERIOD_PS);
    localparam int NUM_REFS   = 2;

    logic [NUM_REFS-1:0] tgl_w;
    logic [NUM_REFS-1:0] alive_w;
    logic                start_w;
    seq_out_t            out_w;

    assign tgl_w = {ref1_tgl_i, ref0_tgl_i};

    for (genvar g = 0; g < NUM_REFS; g++) begin : g_mon
        refsw_activity_mon #(.WINDOW(ACT_WINDOW)) mon_i (
            .clk     (clk),
            .rst     (rst),
            .tgl_i   (tgl_w[g]),
            .alive_o (alive_w[g])
        );
    end

    refsw_req_edge edge_i (
        .clk    (clk),
        .rst    (rst),
        .req_i  (sw_req_i),
        .rise_o (start_w)
    );

    refsw_ctrl #(
        .RST_CYCLES   (RST_CYCLES),
        .LOCK_TIMEOUT (LOCK_TIMEOUT)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_w),
        .refs_ok_i (&alive_w),
        .locked_i  (pll_locked_i),
        .out_o     (out_w)
    );

    assign ref_sel_o  = out_w.sel;
    assign pll_rst_o  = out_w.pll_rst;
    assign out_en_o   = out_w.out_en;
    assign busy_o     = out_w.busy;
    assign refused_o  = out_w.refused;
    assign lock_err_o = out_w.lock_err;
endmodule

// File: rtl/refsw_checker.sv
module refsw_checker (
    input logic clk,
    input logic rst,
    input logic pll_locked_i,
    input logic ref_sel_o,
    input logic pll_rst_o,
    input logic out_en_o,
    input logic refused_o,
    input logic lock_err_o
);
    assert_sel_moves_into_rst_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_sel_o) |-> pll_rst_o);

    assert_rst_starts_with_sel_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_rst_o) |-> !$stable(ref_sel_o));

    assert_gated_during_rst_R7: assert property (@(posedge clk) disable iff (rst)
        pll_rst_o |-> !out_en_o);

    assert_enable_after_lock_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(out_en_o) |-> $past(pll_locked_i, 2));

    assert_timeout_keeps_gate_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_err_o) |-> !out_en_o);

    assert_refusal_keeps_sel_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(refused_o) |-> $stable(ref_sel_o));
endmodule

bind refclk_switch_seq refsw_checker chk_i (
    .clk          (clk),
    .rst          (rst),
    .pll_locked_i (pll_locked_i),
    .ref_sel_o    (ref_sel_o),
    .pll_rst_o    (pll_rst_o),
    .out_en_o     (out_en_o),
    .refused_o    (refused_o),
    .lock_err_o   (lock_err_o)
);

// File: tb/refclk_switch_seq_tb_top.sv
`timescale 1ns/1ps
module refclk_switch_seq_tb_top;
    localparam int WIN = 16;
    localparam int LT  = 40;
    localparam int RC  = (10000 + 8000 - 1) / 8000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_req = 1'b0;
    logic [1:0] tgl = 2'b00;
    logic [1:0] run = 2'b11;
    logic locked = 1'b0;
    logic pll_ok = 1'b1;
    int   lk_cnt = 0;
    logic ref_sel, pll_rst, out_en, busy, refused, lock_err;

    int n_tests = 0;
    int n_fail  = 0;
    int n_cyc   = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    refclk_switch_seq dut_i (
        .clk(clk), .rst(rst), .sw_req_i(sw_req),
        .ref0_tgl_i(tgl[0]), .ref1_tgl_i(tgl[1]), .pll_locked_i(locked),
        .ref_sel_o(ref_sel), .pll_rst_o(pll_rst), .out_en_o(out_en),
        .busy_o(busy), .refused_o(refused), .lock_err_o(lock_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference stimulus: toggles and a simple PLL lock model
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) if (run[i]) tgl[i] <= ~tgl[i];
        if (pll_rst) begin
            locked <= 1'b0;
            lk_cnt <= 0;
        end else if (!locked && pll_ok) begin
            if (lk_cnt == 5) locked <= 1'b1;
            else lk_cnt <= lk_cnt + 1;
        end
    end

    // behavioural reference model
    int  q0[$], q1[$];
    int  n = 0;
    bit  seen0 = 0, seen1 = 0;
    bit  m_prev = 0, started = 0;
    int  stage = 4, k = 0;
    bit  m_sel = 0, m_en = 0, m_ref = 0, m_err = 0;

    function automatic bit alive_of(input int q[$], input int e);
        for (int j = q.size() - 1; j >= 0; j--)
            if (q[j] <= e - 3) return (e - 3 - q[j]) < WIN;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        bit a0, a1, rise;
        n++;
        a0 = alive_of(q0, n);
        a1 = alive_of(q1, n);
        if (rst) begin
            q0.delete(); q1.delete();
            seen0 = 0; seen1 = 0; m_prev = 0;
            stage = 4; k = 0; m_sel = 0; m_en = 0; m_ref = 0; m_err = 0;
        end else begin
            if (tgl[0] != seen0) q0.push_back(n);
            if (tgl[1] != seen1) q1.push_back(n);
            seen0 = tgl[0]; seen1 = tgl[1];
            while (q0.size() > 64) void'(q0.pop_front());
            while (q1.size() > 64) void'(q1.pop_front());
            rise = sw_req && !m_prev;
            m_prev = sw_req;
            case (stage)
                0: if (rise) stage = 1;
                1: if (a0 && a1) begin m_ref = 0; stage = 2; end
                   else begin m_ref = 1; stage = 0; end
                2: begin m_sel = !m_sel; m_en = 0; k = 0; stage = 3; end
                3: if (k == RC - 1) begin k = 0; stage = 4; end else k++;
                4: if (locked) stage = 5;
                   else if (k == LT - 1) begin m_err = 1; k = 0; stage = 0; end
                   else k++;
                5: begin m_en = 1; m_err = 0; stage = 0; end
                default: stage = 0;
            endcase
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            chk(ref_sel  == m_sel,        "R3 ref_sel",   ref_sel,  m_sel);
            chk(pll_rst  == (stage == 3), "R6 pll_rst",   pll_rst,  stage == 3);
            chk(out_en   == m_en,         "R7 out_en",    out_en,   m_en);
            chk(busy     == (stage != 0), "R9 busy",      busy,     stage != 0);
            chk(refused  == m_ref,        "R10 refused",  refused,  m_ref);
            chk(lock_err == m_err,        "R8 lock_err",  lock_err, m_err);
        end
    end

    task automatic pulse_req();
        @(negedge clk) sw_req = 1'b1;
        @(negedge clk) sw_req = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int lim;
        lim = 0;
        repeat (3) @(negedge clk);
        while (busy && lim < 300) begin
            @(negedge clk);
            lim++;
        end
        chk(!busy, tag, busy, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(ref_sel == 0 && out_en == 0 && pll_rst == 0, "R1 reset outputs", {ref_sel, out_en, pll_rst}, 0);
        chk(refused == 0 && lock_err == 0 && busy == 1, "R1 reset flags", {refused, lock_err, busy}, 1);
        rst = 1'b0;
        wait_idle("R1 startup idle");
        chk(out_en == 1, "R1 startup enable", out_en, 1);

        repeat (WIN + 5) @(negedge clk);
        pulse_req();
        wait_idle("R3 idle");
        chk(ref_sel == 1 && out_en == 1, "R3 first switch", {ref_sel, out_en}, 3);

        @(negedge clk) sw_req = 1'b1;
        wait_idle("R2 idle");
        repeat (20) @(negedge clk);
        chk(ref_sel == 0 && !busy, "R2 held request", {ref_sel, busy}, 0);
        sw_req = 1'b0;
        repeat (10) @(negedge clk);
        chk(ref_sel == 0 && !busy, "R2 falling edge", {ref_sel, busy}, 0);

        pulse_req();
        repeat (2) @(negedge clk);
        pulse_req();
        wait_idle("R9 idle");
        repeat (5) @(negedge clk);
        chk(ref_sel == 1 && !busy, "R9 busy request ignored", {ref_sel, busy}, 2);

        run[1] = 1'b0;
        repeat (WIN + 10) @(negedge clk);
        pulse_req();
        wait_idle("R4 idle");
        chk(refused == 1 && ref_sel == 1 && out_en == 1, "R4 dead reference", {refused, ref_sel, out_en}, 7);
        chk(refused == 1, "R5 silent toggle is dead", refused, 1);

        run[1] = 1'b1;
        repeat (10) @(negedge clk);
        pulse_req();
        wait_idle("R10 idle");
        chk(refused == 0 && ref_sel == 0 && out_en == 1, "R10 refusal cleared", {refused, ref_sel, out_en}, 1);

        pll_ok = 1'b0;
        pulse_req();
        wait_idle("R8 idle");
        chk(lock_err == 1 && out_en == 0 && ref_sel == 1, "R8 timeout", {lock_err, out_en, ref_sel}, 5);
        pll_ok = 1'b1;
        repeat (15) @(negedge clk);
        chk(out_en == 0 && locked == 1, "R8 stays gated", {out_en, locked}, 1);
        pulse_req();
        wait_idle("R8 recover idle");
        chk(lock_err == 0 && out_en == 1 && ref_sel == 0, "R8 recovery", {lock_err, out_en, ref_sel}, 2);

        repeat (5) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 100000 && !done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", n_cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule